// File: doc/BRIEF.md
# Segment Selector Stack Access Unit

This unit carries out a single push or pop of a 16-bit segment selector on a stack held in external memory. A request supplies the direction, the operand size (16 or 32 bit), the stack width (16 or 32 bit), the current stack pointer, the segment limit, the selector to push and an access-width policy. From these the unit forms the memory address, the byte enables and the write data. It checks the last byte touched against the segment limit, runs one request/response transfer on its memory port and commits the new stack pointer once the transfer completes.

Two access-width policies are available. In narrow mode every selector access is two bytes, whatever the operand size. A 32-bit push then leaves the upper two bytes of the slot untouched, and a 32-bit pop reads only the low two bytes. In full mode the access width follows the operand size, and a 32-bit push stores zeros in the upper half. The policy changes which accesses hit a limit fault. A faulting request makes no memory access, keeps the stack pointer and raises a one-cycle fault pulse, so the operation can be restarted.

Top module: `sel_stack_unit`

## Requirements
- R1: A push first lowers the stack pointer by the operand size (2 for op32_i=0, 4 for op32_i=1) and writes at the lowered pointer. sp_o takes the lowered value in the cycle done_o is high.
- R2: A push in narrow mode (full_i=0) drives mem_be_o=4'b0011 and mem_we_o=1 for both operand sizes. mem_wdata_o is {16'h0, sel_i}.
- R3: A push in full mode (full_i=1) drives mem_be_o=4'b1111 for op32_i=1 and 4'b0011 for op32_i=0. mem_wdata_o is {16'h0, sel_i}, so the upper half is written as zero.
- R4: A pop in narrow mode reads with mem_be_o=4'b0011 and mem_we_o=0 at the current stack pointer. The stack pointer then rises by the operand size.
- R5: A pop in full mode reads with mem_be_o=4'b1111 for op32_i=1 and 4'b0011 for op32_i=0. The stack pointer then rises by the operand size.
- R6: With a 16-bit stack (stk32_i=0), only sp[15:0] is updated, and it wraps modulo 2^16. sp[31:16] is kept, and mem_addr_o is {16'h0, low half}. For example, a pop from low half 0xFFFC with a 32-bit operand leaves the low half at 0x0000.
- R7: A limit fault occurs when the address of the last enabled byte is greater than limit_i. A 32-bit access whose third or fourth byte is beyond the limit faults in full mode but not in narrow mode.
- R8: On a fault, fault_o is high for one cycle, starting the cycle after the request. mem_req_o stays low, done_o stays low, and sp_o equals the requested sp_i.
- R9: After a pop, sel_o equals mem_rdata_i[15:0] from the acknowledged cycle. The upper read bytes are ignored.
- R10: mem_req_o and busy_o go high the cycle after an accepted request. The address and enables hold until the cycle in which mem_ack_i is sampled high. req_i is ignored while busy_o is high.
- R11: Out of reset, busy_o, done_o, fault_o, mem_req_o, sp_o and sel_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Start an operation (taken when not busy) |
| pop_i | input | 1 | 1 = pop, 0 = push |
| op32_i | input | 1 | Operand size: 1 = 32 bit, 0 = 16 bit |
| stk32_i | input | 1 | Stack width: 1 = 32 bit, 0 = 16 bit |
| full_i | input | 1 | Access policy: 1 = full width, 0 = narrow |
| sp_i | input | 32 | Current stack pointer |
| limit_i | input | 32 | Segment limit (highest valid offset) |
| sel_i | input | 16 | Selector to push |
| busy_o | output | 1 | Memory transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | One-cycle limit-fault pulse |
| sp_o | output | 32 | Committed stack pointer |
| sel_o | output | 16 | Popped selector |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_be_o | output | 4 | Byte enables, bit 0 = byte at mem_addr_o |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Memory response |
| mem_rdata_i | input | 32 | Read data |

## Verification
Pushes and pops are run with each combination of operand size and access policy, so that the byte enables and the pointer steps tell narrow access apart from full-width access. Pops from 0xFFFC and 0xFFFE, and a push from 0x0000, on a 16-bit stack show that only the low half wraps while the upper half is kept. A pair of accesses set against a limit shows that only the full-width access faults when its top two bytes cross the limit. The boundary case where the last byte sits exactly on the limit shows that no fault is raised there. Requests made while a transfer is waiting for its acknowledge show whether the held address survives and whether a second operation starts.

// File: rtl/sss_pkg.sv
package sss_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SEL_W   = 16;
  localparam int unsigned SHORT_W = 16;

  typedef struct packed {
    logic pop;
    logic op32;
    logic stk32;
    logic full;
  } sss_mode_t;

  typedef enum logic {ST_IDLE, ST_ACCESS} sss_state_e;
endpackage

// File: rtl/sss_addr_gen.sv
module sss_addr_gen
  import sss_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SW  = SHORT_W
) (
  input  sss_mode_t       mode_i,
  input  logic [AW-1:0]   sp_i,
  output logic [AW-1:0]   addr_o,
  output logic [AW-1:0]   sp_next_o,
  output logic [DW/8-1:0] be_o,
  output logic            wide_o
);
  localparam int unsigned BEW  = DW / 8;
  localparam int unsigned HALF = BEW / 2;

  logic [AW-1:0] step;
  logic [AW-1:0] sp_long;
  logic [SW-1:0] sp_short;

  always_comb begin
    step     = mode_i.op32 ? AW'(BEW) : AW'(HALF);
    sp_long  = mode_i.pop ? sp_i + step : sp_i - step;
    sp_short = mode_i.pop ? sp_i[SW-1:0] + step[SW-1:0]
                          : sp_i[SW-1:0] - step[SW-1:0];
    if (mode_i.stk32) begin
      sp_next_o = sp_long;
      addr_o    = mode_i.pop ? sp_i : sp_long;
    end else begin
      sp_next_o = {sp_i[AW-1:SW], sp_short};
      addr_o    = mode_i.pop ? {{(AW-SW){1'b0}}, sp_i[SW-1:0]}
                             : {{(AW-SW){1'b0}}, sp_short};
    end
  end

  assign wide_o = mode_i.full & mode_i.op32;

  for (genvar i = 0; i < BEW; i++) begin : g_be
    if (i < HALF) begin : g_lo
      assign be_o[i] = 1'b1;
    end else begin : g_hi
      assign be_o[i] = wide_o;
    end
  end
endmodule

// File: rtl/sss_limit_chk.sv
module sss_limit_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          wide_i,
  input  logic [AW-1:0] limit_i,
  output logic          fault_o
);
  localparam int unsigned BEW = DW / 8;

  logic [AW:0] last;

  // carry bit catches accesses that run past the top of the address space
  always_comb begin
    last    = {1'b0, addr_i} + (wide_i ? (AW+1)'(BEW - 1) : (AW+1)'(BEW/2 - 1));
    fault_o = last > {1'b0, limit_i};
  end
endmodule

// File: rtl/sss_seq.sv
module sss_seq
  import sss_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned SLW = SEL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            pop_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [SLW-1:0]  sel_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [AW-1:0]   sp_next_i,
  input  logic [DW/8-1:0] be_i,
  input  logic            flt_i,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fault_o,
  output logic [AW-1:0]   sp_o,
  output logic [SLW-1:0]  sel_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0]   mem_wdata_o
);
  sss_state_e    state_q;
  logic [AW-1:0] sp_pend_q;
  logic          pop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      sp_pend_q   <= '0;
      pop_q       <= 1'b0;
      done_o      <= 1'b0;
      fault_o     <= 1'b0;
      sp_o        <= '0;
      sel_o       <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_be_o    <= '0;
      mem_wdata_o <= '0;
    end else begin
      done_o  <= 1'b0;
      fault_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (flt_i) begin
              fault_o <= 1'b1;
              sp_o    <= sp_i;
            end else begin
              state_q     <= ST_ACCESS;
              mem_req_o   <= 1'b1;
              mem_we_o    <= ~pop_i;
              mem_addr_o  <= addr_i;
              mem_be_o    <= be_i;
              mem_wdata_o <= {{(DW-SLW){1'b0}}, sel_i};
              sp_pend_q   <= sp_next_i;
              pop_q       <= pop_i;
            end
          end
        end
        ST_ACCESS: begin
          if (mem_ack_i) begin
            state_q   <= ST_IDLE;
            mem_req_o <= 1'b0;
            done_o    <= 1'b1;
            sp_o      <= sp_pend_q;
            if (pop_q) sel_o <= mem_rdata_i[SLW-1:0];
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == ST_ACCESS);

  // R8: a fault never coincides with a memory access
  a_r8_fault_no_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!mem_req_o && !done_o));

  // R10: request and address held until acknowledged
  a_r10_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_be_o)));

  // R10: completion only follows an acknowledged request
  a_r10_done_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(mem_req_o && mem_ack_i));

  // R1: stack pointer changes only on completion or fault
  a_r1_sp_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sp_o) |-> (done_o || fault_o));

  // R9: selector result changes only on completion
  a_r9_sel_on_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sel_o) |-> done_o);
endmodule

// File: rtl/sel_stack_unit.sv
module sel_stack_unit
  import sss_pkg::*;
#(
  parameter int unsigned AW  = ADDR_W,
  parameter int unsigned DW  = DATA_W,
  parameter int unsigned SLW = SEL_W,
  parameter int unsigned SW  = SHORT_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            pop_i,
  input  logic            op32_i,
  input  logic            stk32_i,
  input  logic            full_i,
  input  logic [AW-1:0]   sp_i,
  input  logic [AW-1:0]   limit_i,
  input  logic [SLW-1:0]  sel_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            fault_o,
  output logic [AW-1:0]   sp_o,
  output logic [SLW-1:0]  sel_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [DW/8-1:0] mem_be_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic            mem_ack_i,
  input  logic [DW-1:0]   mem_rdata_i
);
  sss_mode_t       mode;
  logic [AW-1:0]   addr;
  logic [AW-1:0]   sp_next;
  logic [DW/8-1:0] be;
  logic            wide;
  logic            flt;

  assign mode = '{pop: pop_i, op32: op32_i, stk32: stk32_i, full: full_i};

  sss_addr_gen #(.AW(AW), .DW(DW), .SW(SW)) u_addr (
    .mode_i    (mode),
    .sp_i      (sp_i),
    .addr_o    (addr),
    .sp_next_o (sp_next),
    .be_o      (be),
    .wide_o    (wide)
  );

  sss_limit_chk #(.AW(AW), .DW(DW)) u_lim (
    .addr_i  (addr),
    .wide_i  (wide),
    .limit_i (limit_i),
    .fault_o (flt)
  );

  sss_seq #(.AW(AW), .DW(DW), .SLW(SLW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .pop_i       (pop_i),
    .sp_i        (sp_i),
    .sel_i       (sel_i),
    .addr_i      (addr),
    .sp_next_i   (sp_next),
    .be_i        (be),
    .flt_i       (flt),
    .mem_ack_i   (mem_ack_i),
    .mem_rdata_i (mem_rdata_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .fault_o     (fault_o),
    .sp_o        (sp_o),
    .sel_o       (sel_o),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_be_o    (mem_be_o),
    .mem_wdata_o (mem_wdata_o)
  );

  // R10: busy and a pending request go together
  a_r10_busy_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == mem_req_o);

  // R2: narrow policy never enables the upper half
  a_r2_narrow_be: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o && !full_i && !flt) |=> (mem_be_o[DW/8-1:DW/16] == '0));
endmodule

// File: tb/tb_sel_stack_unit.sv
module tb_sel_stack_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, pop = 1'b0, op32 = 1'b0, stk32 = 1'b0, full = 1'b0;
  logic [31:0] sp = '0, lim = '0;
  logic [15:0] sel = '0;
  logic        busy, done, fault, mem_req, mem_we;
  logic [31:0] sp_o, mem_addr, mem_wdata;
  logic [15:0] sel_o;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  sel_stack_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .pop_i(pop), .op32_i(op32),
    .stk32_i(stk32), .full_i(full), .sp_i(sp), .limit_i(lim), .sel_i(sel),
    .busy_o(busy), .done_o(done), .fault_o(fault), .sp_o(sp_o), .sel_o(sel_o),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata)
  );

  typedef struct packed {
    logic        pop, op32, stk32, full;
    logic [31:0] sp, lim;
    logic [15:0] sel;
    logic [31:0] rdata;
    logic        efault;
    logic [31:0] eaddr;
    logic [3:0]  ebe;
    logic [31:0] esp;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 15;
  // R1 R2 R3 R4 R5 R6 R7 R8 tagged per row
  localparam vec_t VECS [NV] = '{
    '{0,0,1,0, 32'h0000_1000, 32'hFFFF_FFFF, 16'h1234, 32'h0,         0, 32'h0000_0FFE, 4'h3, 32'h0000_0FFE, 8'd1},
    '{0,1,1,0, 32'h0000_1000, 32'hFFFF_FFFF, 16'h4321, 32'h0,         0, 32'h0000_0FFC, 4'h3, 32'h0000_0FFC, 8'd2},
    '{0,1,1,1, 32'h0000_1000, 32'hFFFF_FFFF, 16'hBEEF, 32'h0,         0, 32'h0000_0FFC, 4'hF, 32'h0000_0FFC, 8'd3},
    '{0,0,1,1, 32'h0000_1000, 32'hFFFF_FFFF, 16'h00A5, 32'h0,         0, 32'h0000_0FFE, 4'h3, 32'h0000_0FFE, 8'd3},
    '{1,1,1,0, 32'h0000_2000, 32'hFFFF_FFFF, 16'h0,    32'hABCD_5678, 0, 32'h0000_2000, 4'h3, 32'h0000_2004, 8'd4},
    '{1,1,1,1, 32'h0000_2000, 32'hFFFF_FFFF, 16'h0,    32'h1111_9ABC, 0, 32'h0000_2000, 4'hF, 32'h0000_2004, 8'd5},
    '{1,0,1,1, 32'h0000_2000, 32'hFFFF_FFFF, 16'h0,    32'h2222_0F0F, 0, 32'h0000_2000, 4'h3, 32'h0000_2002, 8'd5},
    '{1,1,0,1, 32'h1234_FFFC, 32'h0000_FFFF, 16'h0,    32'h3333_C001, 0, 32'h0000_FFFC, 4'hF, 32'h1234_0000, 8'd6},
    '{1,0,0,0, 32'hABCD_FFFE, 32'h0000_FFFF, 16'h0,    32'h4444_7E57, 0, 32'h0000_FFFE, 4'h3, 32'hABCD_0000, 8'd6},
    '{0,0,0,0, 32'h5555_0000, 32'h0000_FFFF, 16'h7777, 32'h0,         0, 32'h0000_FFFE, 4'h3, 32'h5555_FFFE, 8'd6},
    '{1,1,1,1, 32'h0000_0FFE, 32'h0000_0FFF, 16'h0,    32'h0,         1, 32'h0,         4'h0, 32'h0000_0FFE, 8'd7},
    '{1,1,1,0, 32'h0000_0FFE, 32'h0000_0FFF, 16'h0,    32'h5555_1357, 0, 32'h0000_0FFE, 4'h3, 32'h0000_1002, 8'd7},
    '{0,1,1,1, 32'h0000_1002, 32'h0000_1000, 16'h2468, 32'h0,         1, 32'h0,         4'h0, 32'h0000_1002, 8'd7},
    '{0,1,1,0, 32'h0000_1002, 32'h0000_1000, 16'h2468, 32'h0,         0, 32'h0000_0FFE, 4'h3, 32'h0000_0FFE, 8'd7},
    '{0,0,1,0, 32'h0000_0000, 32'h0000_0FFF, 16'h1111, 32'h0,         1, 32'h0,         4'h0, 32'h0000_0000, 8'd8}
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R11: reset values
    #1;
    chk(busy == 0 && done == 0 && fault == 0 && mem_req == 0, "R11 ctrl", {28'h0, busy, done, fault, mem_req}, 32'h0);
    chk(sp_o == 0 && sel_o == 0, "R11 data", sp_o | {16'h0, sel_o}, 32'h0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && mem_req == 0, "R11 after release", {30'h0, busy, mem_req}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v = VECS[i];
      string t = $sformatf("R%0d vec%0d", v.rq, i);
      @(negedge clk);
      pop = v.pop; op32 = v.op32; stk32 = v.stk32; full = v.full;
      sp = v.sp; lim = v.lim; sel = v.sel; req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      if (v.efault) begin
        chk(fault == 1'b1, {t, " fault"}, {31'h0, fault}, 32'h1);
        chk(mem_req == 1'b0 && done == 1'b0, {t, " R8 no access"}, {30'h0, mem_req, done}, 32'h0);
        chk(sp_o == v.sp, {t, " R8 sp kept"}, sp_o, v.sp);
        @(negedge clk);
        chk(fault == 1'b0 && busy == 1'b0, {t, " R8 pulse"}, {30'h0, fault, busy}, 32'h0);
      end else begin
        chk(mem_req == 1'b1 && busy == 1'b1 && fault == 1'b0, {t, " R10 req"}, {29'h0, mem_req, busy, fault}, 32'h6);
        chk(mem_addr == v.eaddr, {t, " addr"}, mem_addr, v.eaddr);
        chk(mem_be == v.ebe, {t, " be"}, {28'h0, mem_be}, {28'h0, v.ebe});
        chk(mem_we == !v.pop, {t, " we"}, {31'h0, mem_we}, {31'h0, !v.pop});
        if (!v.pop)
          chk(mem_wdata == {16'h0, v.sel}, {t, " wdata"}, mem_wdata, {16'h0, v.sel});
        // R10: request while busy must be ignored
        sp = 32'hDEAD_0000; req = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk(mem_req == 1'b1 && mem_addr == v.eaddr && done == 1'b0, {t, " R10 hold"}, mem_addr, v.eaddr);
        mem_ack = 1'b1;
        mem_rdata = v.rdata;
        @(negedge clk);
        mem_ack = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, {t, " R10 done"}, {30'h0, done, busy}, 32'h2);
        chk(sp_o == v.esp, {t, " R1 sp"}, sp_o, v.esp);
        if (v.pop)
          chk(sel_o == v.rdata[15:0], {t, " R9 sel"}, {16'h0, sel_o}, {16'h0, v.rdata[15:0]});
        @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0, {t, " R10 no restart"}, {30'h0, done, mem_req}, 32'h0);
      end
    end
    summary();
  end
endmodule